// File: doc/BRIEF.md
# USB Host Control-Read Status Stage Sequencer

This block is the host-side endpoint-0 logic that finishes a control read. After the IN data stage, software starts the OUT status stage. It does this by writing the endpoint-0 control/status register with the status-packet bit and the packet-ready bit both set. The block then asks an abstract packet engine to send an OUT token followed by a DATA1 packet with no payload. It reads the handshake that the engine reports back and decides what to do next.

An ACK ends the stage cleanly. A STALL ends it with a stall flag. Three attempts in a row with no response end it with an error flag. A run of NAKs that lasts longer than a programmable number of frames sets a NAK-timeout flag and parks the transaction. From there, software either resumes it by clearing the flag, or aborts it by flushing first and then clearing the flag. Every ending raises a sticky endpoint-0 interrupt.

Register view (`csr_rd`): bit 1 packet-ready, bit 2 stall flag, bit 4 error flag, bit 6 status-packet, bit 7 NAK-timeout; all other bits read 0. Handshake codes on `pe_hs`: 0 ACK, 1 NAK, 2 STALL, 3 no response.

Top module: `usb_status_seq`

## Requirements
- R1: A write starts the stage only when it has bit 6 and bit 1 both set and the block is idle. A write with only one of the two bits leaves `csr_rd` bits 6 and 1 at 0 and issues no request.
- R2: Each attempt is a one-cycle `pe_start` pulse with `pe_data1`=1 and `pe_len`=0. The first pulse is visible in the cycle after the starting write's clock edge.
- R3: An ACK (code 0) clears bits 6 and 1, sets no flag and sets `irq`.
- R4: A STALL (code 2) sets bit 2, clears bits 6 and 1 and sets `irq`.
- R5: Three consecutive no-response results (code 3) set bit 4, clear bits 6 and 1, set `irq` and stop the requests. Any handshake in between restarts the count from zero.
- R6: With `nak_limit` L>0, a NAK received once L or more frame strobes have been counted during the active stage sets bit 7 and `irq`. No further request is made while bit 7 stays set.
- R7: With `nak_limit`=0, NAKs never time out.
- R8: Writing 0 to bit 7 while parked, with no flush since the timeout, resumes the same transaction with a fresh NAK-time window.
- R9: A `flush` pulse while parked, followed by a write of 0 to bit 7, aborts the transaction: no request is made and bits 6, 1 and 7 read 0.
- R10: Bits 2, 4 and 7 clear only when written with 0 and hold when written with 1. `irq` stays high until `irq_clr` is pulsed.
- R11: After reset `csr_rd` is 0, `irq` is 0 and `pe_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| csr_rd | output | 8 | Register read view |
| flush | input | 1 | FIFO flush pulse |
| nak_limit | input | 8 | NAK time limit in frames, 0 disables |
| frame_tick | input | 1 | One-cycle frame strobe |
| pe_start | output | 1 | Request one OUT + DATA1 attempt |
| pe_data1 | output | 1 | Data PID toggle of the request (1 = DATA1) |
| pe_len | output | 11 | Payload length of the request |
| pe_done | input | 1 | Attempt finished, handshake valid |
| pe_hs | input | 2 | Handshake code |
| irq | output | 1 | Endpoint-0 interrupt |
| irq_clr | input | 1 | Interrupt acknowledge |

## Verification
The bench goes after the retry count in several ways:
- Exactly three silent attempts must end the stage. A design that stops one early or one late shows a wrong number of `pe_start` pulses.
- A NAK between silent attempts must reset the count. A counter that is not cleared by a handshake would raise a false error.

The NAK window is probed at limit 2 and at limit 0. Resuming is tested to check that the frame count restarts; a design that kept the old count would time out again on the first NAK. The abort path is driven through flush-then-clear, where a design that ignores the flush would emit one more request. Written-1 bits are checked to confirm that they keep the flags, and the interrupt is checked to stay high across idle cycles.

// File: rtl/usb_ss_pkg.sv
package usb_ss_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } st_e;

  localparam int B_TXRDY = 1;
  localparam int B_STALL = 2;
  localparam int B_ERR   = 4;
  localparam int B_STPKT = 6;
  localparam int B_NAKTO = 7;
endpackage

// File: rtl/usb_ss_retry.sv
module usb_ss_retry #(
  parameter int TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(TRIES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(TRIES - 1));

  // R5: the sequencer must end the stage rather than count past the cap
  assert_retry_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last);
endmodule

// File: rtl/usb_ss_naktmr.sv
module usb_ss_naktmr #(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            tick,
  input  logic [LIMW-1:0] limit,
  output logic            expired
);
  logic [LIMW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = clr || (run && tick && (cnt_q != '1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (limit != '0) && (cnt_q >= limit);

  // R7: a zero limit can never report expiry
  assert_zero_limit_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !expired);
endmodule

// File: rtl/usb_ss_fsm.sv
module usb_ss_fsm
  import usb_ss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       resume,
  input  logic       abort,
  input  logic       pe_done,
  input  logic [1:0] pe_hs,
  input  logic       retry_last,
  input  logic       nak_expired,
  output logic       pe_start,
  output logic       ev_ack,
  output logic       ev_stall,
  output logic       ev_err,
  output logic       ev_nakto,
  output logic       ev_abort,
  output logic       retry_clr,
  output logic       retry_inc,
  output logic       nak_clr,
  output logic       nak_run,
  output logic       is_idle,
  output logic       in_hold
);
  st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    pe_start  = 1'b0;
    ev_ack    = 1'b0;
    ev_stall  = 1'b0;
    ev_err    = 1'b0;
    ev_nakto  = 1'b0;
    ev_abort  = 1'b0;
    retry_clr = 1'b0;
    retry_inc = 1'b0;
    nak_clr   = 1'b0;
    nak_run   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_ISSUE;
          retry_clr = 1'b1;
          nak_clr   = 1'b1;
        end
      end
      ST_ISSUE: begin
        pe_start = 1'b1;
        nak_run  = 1'b1;
        st_d     = ST_WAIT;
      end
      ST_WAIT: begin
        nak_run = 1'b1;
        if (pe_done) begin
          unique case (hs_e'(pe_hs))
            HS_ACK: begin
              ev_ack    = 1'b1;
              retry_clr = 1'b1;
              st_d      = ST_IDLE;
            end
            HS_STALL: begin
              ev_stall  = 1'b1;
              retry_clr = 1'b1;
              st_d      = ST_IDLE;
            end
            HS_NONE: begin
              if (retry_last) begin
                ev_err    = 1'b1;
                retry_clr = 1'b1;
                st_d      = ST_IDLE;
              end else begin
                retry_inc = 1'b1;
                st_d      = ST_ISSUE;
              end
            end
            HS_NAK: begin
              retry_clr = 1'b1;
              if (nak_expired) begin
                ev_nakto = 1'b1;
                st_d     = ST_HOLD;
              end else begin
                st_d = ST_ISSUE;
              end
            end
            default: st_d = st_q;
          endcase
        end
      end
      ST_HOLD: begin
        if (abort) begin
          ev_abort = 1'b1;
          st_d     = ST_IDLE;
        end else if (resume) begin
          retry_clr = 1'b1;
          nak_clr   = 1'b1;
          st_d      = ST_ISSUE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign is_idle = (st_q == ST_IDLE);
  assign in_hold = (st_q == ST_HOLD);

  // R8: clearing the timeout without a pending abort re-issues next cycle
  assert_resume_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && resume && !abort) |=> pe_start);

  // R9: an abort from the parked state returns to idle with no request
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (is_idle && !pe_start));

  // R6: while parked no request leaves the block
  assert_hold_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !resume) |=> !pe_start);
endmodule

// File: rtl/usb_status_seq.sv
module usb_status_seq
  import usb_ss_pkg::*;
#(
  parameter int LIMW  = 8,
  parameter int LENW  = 11,
  parameter int TRIES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      csr_rd,
  input  logic            flush,
  input  logic [LIMW-1:0] nak_limit,
  input  logic            frame_tick,
  output logic            pe_start,
  output logic            pe_data1,
  output logic [LENW-1:0] pe_len,
  input  logic            pe_done,
  input  logic [1:0]      pe_hs,
  output logic            irq,
  input  logic            irq_clr
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ns = rst_s2_q;

  logic stpkt_q, txrdy_q, stall_q, err_q, nakto_q, abort_q, irq_q;
  logic stpkt_d, txrdy_d, stall_d, err_d, nakto_d, abort_d, irq_d;
  logic is_idle, in_hold, start, nakto_wr0, resume, abort_go, ev_end;
  logic ev_ack, ev_stall, ev_err, ev_nakto, ev_abort;
  logic retry_clr, retry_inc, retry_last, nak_clr, nak_run, nak_expired;

  assign start     = reg_wr && reg_wdata[B_STPKT] && reg_wdata[B_TXRDY] && is_idle;
  assign nakto_wr0 = reg_wr && !reg_wdata[B_NAKTO] && nakto_q;
  assign resume    = nakto_wr0 && in_hold;
  assign abort_go  = nakto_wr0 && in_hold && abort_q;
  assign ev_end    = ev_ack || ev_stall || ev_err || ev_nakto;

  usb_ss_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start       (start),
    .resume      (resume),
    .abort       (abort_go),
    .pe_done     (pe_done),
    .pe_hs       (pe_hs),
    .retry_last  (retry_last),
    .nak_expired (nak_expired),
    .pe_start    (pe_start),
    .ev_ack      (ev_ack),
    .ev_stall    (ev_stall),
    .ev_err      (ev_err),
    .ev_nakto    (ev_nakto),
    .ev_abort    (ev_abort),
    .retry_clr   (retry_clr),
    .retry_inc   (retry_inc),
    .nak_clr     (nak_clr),
    .nak_run     (nak_run),
    .is_idle     (is_idle),
    .in_hold     (in_hold)
  );

  usb_ss_retry #(.TRIES(TRIES)) u_retry (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (retry_clr),
    .inc   (retry_inc),
    .last  (retry_last)
  );

  usb_ss_naktmr #(.LIMW(LIMW)) u_nak (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clr     (nak_clr),
    .run     (nak_run),
    .tick    (frame_tick),
    .limit   (nak_limit),
    .expired (nak_expired)
  );

  always_comb begin
    stpkt_d = stpkt_q;
    txrdy_d = txrdy_q;
    if (start) begin
      stpkt_d = 1'b1;
      txrdy_d = 1'b1;
    end else if (ev_ack || ev_stall || ev_err || ev_abort) begin
      stpkt_d = 1'b0;
      txrdy_d = 1'b0;
    end

    stall_d = stall_q;
    if (ev_stall)                          stall_d = 1'b1;
    else if (reg_wr && !reg_wdata[B_STALL]) stall_d = 1'b0;

    err_d = err_q;
    if (ev_err)                           err_d = 1'b1;
    else if (reg_wr && !reg_wdata[B_ERR]) err_d = 1'b0;

    nakto_d = nakto_q;
    if (ev_nakto)                           nakto_d = 1'b1;
    else if (reg_wr && !reg_wdata[B_NAKTO]) nakto_d = 1'b0;

    abort_d = abort_q;
    if (!in_hold)   abort_d = 1'b0;
    else if (flush) abort_d = 1'b1;

    irq_d = irq_q;
    if (ev_end)       irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stpkt_q <= 1'b0;
      txrdy_q <= 1'b0;
      stall_q <= 1'b0;
      err_q   <= 1'b0;
      nakto_q <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      stpkt_q <= stpkt_d;
      txrdy_q <= txrdy_d;
      stall_q <= stall_d;
      err_q   <= err_d;
      nakto_q <= nakto_d;
      abort_q <= abort_d;
      irq_q   <= irq_d;
    end
  end

  assign csr_rd   = {nakto_q, stpkt_q, 1'b0, err_q, 1'b0, stall_q, txrdy_q, 1'b0};
  assign irq      = irq_q;
  assign pe_data1 = 1'b1;
  assign pe_len   = '0;

  // R3: an ACK leaves the start bits low and the interrupt raised
  assert_ack_done_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    ev_ack |=> (!csr_rd[B_STPKT] && !csr_rd[B_TXRDY] && irq));

  // R4: a stall handshake is visible in the register next cycle
  assert_stall_flag_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    ev_stall |=> (csr_rd[B_STALL] && irq));

  // R5: the error ending stops the stage
  assert_err_stop_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    ev_err |=> (csr_rd[B_ERR] && is_idle));

  // R6: a new timeout flag always comes with the interrupt
  assert_nakto_irq_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(csr_rd[B_NAKTO]) |-> irq);

  // R10: interrupt holds until acknowledged
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(irq) && !$past(irq_clr)) |-> irq);

  // R1: a request is never issued while the register shows no stage
  assert_req_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    pe_start |-> (csr_rd[B_STPKT] && csr_rd[B_TXRDY]));
endmodule

// File: tb/sim_usb_status_seq.sv
module sim_usb_status_seq;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  csr_rd;
  logic        flush;
  logic [7:0]  nak_limit;
  logic        frame_tick;
  logic        pe_start;
  logic        pe_data1;
  logic [10:0] pe_len;
  logic        pe_done;
  logic [1:0]  pe_hs;
  logic        irq;
  logic        irq_clr;

  int errors = 0;
  int checks = 0;

  always #(CYC/2) clk = ~clk;

  usb_status_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .csr_rd(csr_rd), .flush(flush), .nak_limit(nak_limit),
    .frame_tick(frame_tick), .pe_start(pe_start), .pe_data1(pe_data1),
    .pe_len(pe_len), .pe_done(pe_done), .pe_hs(pe_hs), .irq(irq),
    .irq_clr(irq_clr)
  );

  // vector: wdata[19:12] hs[11:10] exp_csr[9:2] exp_irq[1] exp_go[0]
  localparam logic [19:0] VEC [6] = '{
    {8'h42, 2'd0, 8'h00, 1'b1, 1'b1},   // R3 ACK
    {8'h42, 2'd2, 8'h04, 1'b1, 1'b1},   // R4 STALL
    {8'h40, 2'd0, 8'h00, 1'b0, 1'b0},   // R1 status bit only
    {8'h02, 2'd0, 8'h00, 1'b0, 1'b0},   // R1 ready bit only
    {8'hC2, 2'd0, 8'h00, 1'b1, 1'b1},   // R3 extra bits set
    {8'h46, 2'd2, 8'h04, 1'b1, 1'b1}    // R4 stall flag written 1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic attempt(input logic [1:0] hs, input bit tick, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pe_start) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (seen) begin
      chk(pe_data1 == 1'b1 && pe_len == 11'd0, "R2", {pe_data1, pe_len}, 12'h800);
      frame_tick = tick;
      @(negedge clk);
      frame_tick = 1'b0;
      pe_done    = 1'b1;
      pe_hs      = hs;
      @(negedge clk);
      pe_done    = 1'b0;
    end
  endtask

  task automatic clr_all();
    wr(8'h00);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00; flush = 1'b0;
    nak_limit = 8'd0; frame_tick = 1'b0; pe_done = 1'b0; pe_hs = 2'd0;
    irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(csr_rd == 8'h00, "R11 csr", csr_rd, 0);
    chk(irq == 1'b0, "R11 irq", irq, 0);
    chk(pe_start == 1'b0, "R11 pe_start", pe_start, 0);

    for (int v = 0; v < 6; v++) begin
      wr(VEC[v][19:12]);
      attempt(VEC[v][11:10], 1'b0, seen);
      chk(seen == VEC[v][0], "R1 request", seen, VEC[v][0]);
      chk(csr_rd == VEC[v][9:2], "R3/R4 csr", csr_rd, VEC[v][9:2]);
      chk(irq == VEC[v][1], "R3/R4 irq", irq, VEC[v][1]);
      clr_all();
    end

    // R5: three silent attempts end in error
    wr(8'h42);
    for (int k = 0; k < 3; k++) begin
      attempt(2'd3, 1'b0, seen);
      chk(seen == 1'b1, "R5 attempt", seen, 1);
    end
    attempt(2'd3, 1'b0, seen);
    chk(seen == 1'b0, "R5 stops", seen, 0);
    chk(csr_rd == 8'h10, "R5 csr", csr_rd, 8'h10);
    chk(irq == 1'b1, "R5 irq", irq, 1);
    clr_all();

    // R5: a handshake in between restarts the count
    wr(8'h42);
    attempt(2'd3, 1'b0, seen);
    attempt(2'd3, 1'b0, seen);
    attempt(2'd1, 1'b0, seen);
    attempt(2'd3, 1'b0, seen);
    attempt(2'd3, 1'b0, seen);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b1, "R5 sixth attempt", seen, 1);
    chk(csr_rd == 8'h00, "R5 no error", csr_rd, 0);
    clr_all();

    // R6: timeout at limit 2
    nak_limit = 8'd2;
    wr(8'h42);
    attempt(2'd1, 1'b1, seen);
    attempt(2'd1, 1'b1, seen);
    chk(seen == 1'b1, "R6 second attempt", seen, 1);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b0, "R6 parked", seen, 0);
    chk(csr_rd == 8'hC2, "R6 csr", csr_rd, 8'hC2);
    chk(irq == 1'b1, "R6 irq", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R10 irq held", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 irq_clr", irq, 0);

    // R8: resume with a fresh window
    wr(8'h00);
    attempt(2'd1, 1'b1, seen);
    chk(seen == 1'b1, "R8 resumed", seen, 1);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b1, "R8 fresh window", seen, 1);
    chk(csr_rd == 8'h00, "R8 csr", csr_rd, 0);
    clr_all();

    // R9: flush then clear aborts
    wr(8'h42);
    attempt(2'd1, 1'b1, seen);
    attempt(2'd1, 1'b1, seen);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wr(8'h00);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b0, "R9 no request", seen, 0);
    chk(csr_rd == 8'h00, "R9 csr", csr_rd, 0);
    clr_all();

    // R7: zero limit never times out
    nak_limit = 8'd0;
    wr(8'h42);
    for (int k = 0; k < 6; k++) attempt(2'd1, 1'b1, seen);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b1, "R7 still issuing", seen, 1);
    chk(csr_rd == 8'h00, "R7 csr", csr_rd, 0);
    clr_all();

    // R10: written 1 keeps flags, written 0 clears
    wr(8'h42);
    attempt(2'd2, 1'b0, seen);
    wr(8'h94);
    attempt(2'd0, 1'b0, seen);
    chk(seen == 1'b0, "R10 no start", seen, 0);
    chk(csr_rd == 8'h04, "R10 kept", csr_rd, 8'h04);
    wr(8'h00);
    chk(csr_rd == 8'h00, "R10 cleared", csr_rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule